// File: doc/BRIEF.md
# PCIe Read Request Segmenter

This block accepts one large DMA read command at a time, given as a start address and a byte length, and turns it into a stream of memory read request descriptors. Each descriptor carries a doubleword-aligned address, a length in doublewords and a header tag. The descriptors are sized so that no request exceeds the current maximum read request size and no request crosses a 4 KB address boundary. The descriptors are handed to a downstream header builder over a valid/ready handshake.

The maximum read request size comes from a three-bit power-of-two code in bits 14:12 of a device control word. The block registers this code each clock and takes a snapshot of it when a command is accepted. Every non-posted request takes a tag from a pool. Issuing stops when no tag is free. A tag goes back to the pool when the completion side reports that the final completion for that tag has arrived, and tags may come back in any order. Once every segment has been handed over and every tag has returned, the block raises a one-cycle done pulse and is then ready for the next command.

Top module: `rdreq_splitter`

## Requirements
- R1: The size code is `dev_ctl[14:12]`. It is registered every clock, and the register resets to 3'b010. The request limit is 128 bytes shifted left by the code, so 3'b010 gives 512, 3'b011 gives 1024 and 3'b101 gives 4096. Codes 3'b110 and 3'b111 are treated as 4096. The limit used for a command is the value the register holds on the clock edge that accepts the command.
- R2: The requests of one command are consecutive. The first request starts at the command address, each later request starts where the previous one ended, and together they cover exactly the command length.
- R3: Each request length is the smallest of three values: the bytes still remaining, the size limit, and the bytes left up to the next 4 KB boundary. The length is reported in doublewords, so `req_dw_len` is the byte count divided by 4.
- R4: The tag given to a new request is the lowest-numbered free tag. While `ext_tag_en` is 0, only tags 0 to 31 are used. While it is 1, all 2**TAG_W tags are used.
- R5: While no tag in the allowed range is free, no new request is presented.
- R6: A tag becomes free only on `cpl_valid` with `cpl_last` = 1 and `cpl_tag` equal to that tag. A completion with `cpl_last` = 0 frees nothing. Tags may be freed in any order.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_dw_len` and `req_tag` hold their values.
- R8: `cmd_ready` is high after reset and low from command acceptance until completion. `cmd_done` pulses for exactly one cycle once all segments have been taken and all their tags freed, never earlier.
- R9: A command with a length of 0 produces no request and still produces the `cmd_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ctl | input | 16 | Device control word; bits 14:12 hold the size code |
| ext_tag_en | input | 1 | Allows tags above 31 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_addr | input | ADDR_W | Command start address, DW aligned |
| cmd_len | input | LEN_W | Command length in bytes, multiple of 4 |
| req_valid | output | 1 | Request descriptor valid |
| req_ready | input | 1 | Downstream accepts the descriptor |
| req_addr | output | ADDR_W | Request address |
| req_dw_len | output | 11 | Request length in doublewords |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | Completion report |
| cpl_tag | input | TAG_W | Tag of the completion |
| cpl_last | input | 1 | Completion is the final one for its tag |
| cmd_done | output | 1 | One-cycle pulse at command end |

## Verification
The first descriptor is due in the cycle after the accepting edge. With ready held high, one descriptor follows per cycle. A tag freed on a completion edge can reappear on the very next edge. `cmd_done` rises one edge after the edge that frees the last tag.

The bench drives inputs and samples outputs on the falling edge. It treats a descriptor seen with ready high as taken on the next rising edge, and it waits for each result rather than assuming a fixed latency. In the directed tag test, absence is checked only after several idle cycles have passed.

// File: rtl/rdseg_pkg.sv
package rdseg_pkg;
   localparam int PAGE_BYTES = 4096;
   localparam int PAGE_LSB   = 12;
   localparam int SEG_W      = 13;
   localparam int DWLEN_W    = SEG_W - 2;
   localparam int NORM_TAGS_DEF = 32;
   localparam logic [2:0] SIZE_CODE_RST = 3'b010;

   function automatic logic [SEG_W-1:0] code_to_bytes(input logic [2:0] code,
                                                      input logic [2:0] max_code);
      logic [2:0] c;
      c = (code > max_code) ? max_code : code;
      return SEG_W'(128) << c;
   endfunction

   function automatic logic [SEG_W-1:0] min_bytes(input logic [SEG_W-1:0] a,
                                                  input logic [SEG_W-1:0] b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/rdseg_size_dec.sv
module rdseg_size_dec
   import rdseg_pkg::*;
#(
   parameter int MAX_CODE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       code_in,
   output logic [SEG_W-1:0] size_bytes
);
   logic [2:0] code_q;

   if (MAX_CODE > 5 || MAX_CODE < 0) begin : g_bad_code
      $error("MAX_CODE must lie in 0..5");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= SIZE_CODE_RST;
      else        code_q <= code_in;
   end

   assign size_bytes = code_to_bytes(code_q, 3'(MAX_CODE));

   // R1: decoded limit is a single power of two in the legal range
   p_size_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(size_bytes) == 1 && size_bytes >= SEG_W'(128)
      && size_bytes <= SEG_W'(PAGE_BYTES));
endmodule

// File: rtl/rdseg_tag_pool.sv
module rdseg_tag_pool
   import rdseg_pkg::*;
#(
   parameter int TAG_W     = 6,
   parameter int NORM_TAGS = NORM_TAGS_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_en,
   input  logic             take,
   input  logic             rel_valid,
   input  logic [TAG_W-1:0] rel_tag,
   input  logic             rel_last,
   output logic             avail,
   output logic [TAG_W-1:0] pick,
   output logic             all_free
);
   localparam int FULL_TAGS = 1 << TAG_W;

   logic [FULL_TAGS-1:0] busy;
   logic [FULL_TAGS-1:0] allow;
   logic [FULL_TAGS-1:0] usable;
   logic [FULL_TAGS-1:0] rel_mask;
   logic [FULL_TAGS-1:0] take_mask;
   wire unused_ext = ext_en;

   if (NORM_TAGS < 1 || NORM_TAGS > FULL_TAGS) begin : g_bad_norm
      $error("NORM_TAGS must lie in 1..2**TAG_W");
   end

   for (genvar g = 0; g < FULL_TAGS; g++) begin : g_allow
      if (g < NORM_TAGS) begin : g_base
         assign allow[g] = 1'b1;
      end else begin : g_ext
         assign allow[g] = ext_en;
      end
   end

   assign usable = ~busy & allow;
   assign avail  = |usable;

   always_comb begin
      pick = '0;
      for (int i = FULL_TAGS - 1; i >= 0; i--) begin
         if (usable[i]) pick = TAG_W'(i);
      end
   end

   assign rel_mask  = (rel_valid && rel_last) ? (FULL_TAGS'(1) << rel_tag) : '0;
   assign take_mask = take ? (FULL_TAGS'(1) << pick) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy <= '0;
      else        busy <= (busy & ~rel_mask) | take_mask;
   end

   assign all_free = (busy == '0);

   // R5: the segment engine only takes a tag when one is offered
   p_take_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> avail);
   // R4: without extended tags the pick stays in the base range
   p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ext_en) |-> (int'(pick) < NORM_TAGS));
   // R4: a taken tag leaves the pool busy on the next cycle
   p_take_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !all_free);
endmodule

// File: rtl/rdseg_engine.sv
module rdseg_engine
   import rdseg_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 32,
   parameter int TAG_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [LEN_W-1:0]   cmd_len,
   input  logic [SEG_W-1:0]   size_bytes,
   input  logic               tag_avail,
   input  logic [TAG_W-1:0]   tag_id,
   input  logic               tag_all_free,
   output logic               tag_take,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [DWLEN_W-1:0] req_dw_len,
   output logic [TAG_W-1:0]   req_tag,
   output logic               cmd_done
);
   logic               active;
   logic [LEN_W-1:0]   rem;
   logic [ADDR_W-1:0]  cur;
   logic [SEG_W-1:0]   sz_q;
   logic               o_vld;
   logic [ADDR_W-1:0]  o_addr;
   logic [DWLEN_W-1:0] o_len;
   logic [TAG_W-1:0]   o_tag;
   logic               done_q;

   logic               accept;
   logic               slot_free;
   logic               load;
   logic               finish;
   logic [SEG_W-1:0]   to_page;
   logic [SEG_W-1:0]   rem_clip;
   logic [SEG_W-1:0]   seg;
   wire  unused_len = ^cmd_len[1:0];

   assign cmd_ready = !active;
   assign accept    = cmd_valid && !active;
   assign slot_free = !o_vld || req_ready;

   assign to_page  = SEG_W'(PAGE_BYTES) - {1'b0, cur[PAGE_LSB-1:0]};
   assign rem_clip = (rem > LEN_W'(PAGE_BYTES)) ? SEG_W'(PAGE_BYTES) : rem[SEG_W-1:0];
   assign seg      = min_bytes(min_bytes(rem_clip, sz_q), to_page);

   assign load     = active && (rem != '0) && slot_free && tag_avail;
   assign tag_take = load;
   assign finish   = active && (rem == '0) && !o_vld && tag_all_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         rem    <= '0;
         cur    <= '0;
         sz_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            active <= 1'b1;
            rem    <= {cmd_len[LEN_W-1:2], 2'b00};
            cur    <= cmd_addr;
            sz_q   <= size_bytes;
         end else if (finish) begin
            active <= 1'b0;
            done_q <= 1'b1;
         end else if (load) begin
            cur <= cur + ADDR_W'(seg);
            rem <= rem - LEN_W'(seg);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_vld  <= 1'b0;
         o_addr <= '0;
         o_len  <= '0;
         o_tag  <= '0;
      end else if (load) begin
         o_vld  <= 1'b1;
         o_addr <= cur;
         o_len  <= seg[SEG_W-1:2];
         o_tag  <= tag_id;
      end else if (req_ready) begin
         o_vld <= 1'b0;
      end
   end

   assign req_valid  = o_vld;
   assign req_addr   = o_addr;
   assign req_dw_len = o_len;
   assign req_tag    = o_tag;
   assign cmd_done   = done_q;

   // R7: a stalled descriptor is held unchanged
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
      && $stable(req_dw_len) && $stable(req_tag)));
   // R3: a request never crosses a 4 KB boundary
   p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({2'b00, req_addr[PAGE_LSB-1:0]} + {1'b0, req_dw_len, 2'b00})
      <= 14'(PAGE_BYTES));
   // R3: a request is non-empty and within the latched limit
   p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_dw_len != '0 && {req_dw_len, 2'b00} <= sz_q));
   // R8: done lasts a single cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);
   // R8: done only with no descriptor pending and every tag back
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (tag_all_free && !req_valid));
endmodule

// File: rtl/rdreq_splitter.sv
module rdreq_splitter
   import rdseg_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int LEN_W     = 32,
   parameter int TAG_W     = 6,
   parameter int NORM_TAGS = NORM_TAGS_DEF,
   parameter int MAX_CODE  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        dev_ctl,
   input  logic               ext_tag_en,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [LEN_W-1:0]   cmd_len,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [DWLEN_W-1:0] req_dw_len,
   output logic [TAG_W-1:0]   req_tag,
   input  logic               cpl_valid,
   input  logic [TAG_W-1:0]   cpl_tag,
   input  logic               cpl_last,
   output logic               cmd_done
);
   logic [SEG_W-1:0] size_bytes;
   logic             tag_avail;
   logic [TAG_W-1:0] tag_id;
   logic             tag_all_free;
   logic             tag_take;
   wire  unused_ctl = ^{dev_ctl[15], dev_ctl[11:0]};

   if (ADDR_W < PAGE_LSB + 1) begin : g_bad_addr
      $error("ADDR_W too small");
   end
   if (LEN_W < SEG_W) begin : g_bad_len
      $error("LEN_W too small");
   end
   if (TAG_W < 1 || TAG_W > 10) begin : g_bad_tag
      $error("TAG_W must lie in 1..10");
   end

   rdseg_size_dec #(.MAX_CODE(MAX_CODE)) u_size (
      .clk        (clk),
      .rst_n      (rst_n),
      .code_in    (dev_ctl[14:12]),
      .size_bytes (size_bytes)
   );

   rdseg_tag_pool #(.TAG_W(TAG_W), .NORM_TAGS(NORM_TAGS)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_en    (ext_tag_en),
      .take      (tag_take),
      .rel_valid (cpl_valid),
      .rel_tag   (cpl_tag),
      .rel_last  (cpl_last),
      .avail     (tag_avail),
      .pick      (tag_id),
      .all_free  (tag_all_free)
   );

   rdseg_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_addr     (cmd_addr),
      .cmd_len      (cmd_len),
      .size_bytes   (size_bytes),
      .tag_avail    (tag_avail),
      .tag_id       (tag_id),
      .tag_all_free (tag_all_free),
      .tag_take     (tag_take),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_dw_len   (req_dw_len),
      .req_tag      (req_tag),
      .cmd_done     (cmd_done)
   );
endmodule

// File: tb/rdreq_splitter_bench.sv
`timescale 1ns/1ps
module rdreq_splitter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dev_ctl = 16'h0;
   logic        ext_tag_en = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_addr = '0;
   logic [31:0] cmd_len = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic [10:0] req_dw_len;
   logic [5:0]  req_tag;
   logic        cpl_valid = 1'b0;
   logic [5:0]  cpl_tag = '0;
   logic        cpl_last = 1'b0;
   logic        cmd_done;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   bit [63:0] bmodel = '0;
   int olist[$];

   always #4 clk = ~clk;

   rdreq_splitter u_rdreq_splitter (
      .clk(clk), .rst_n(rst_n), .dev_ctl(dev_ctl), .ext_tag_en(ext_tag_en),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_dw_len(req_dw_len), .req_tag(req_tag),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_last(cpl_last),
      .cmd_done(cmd_done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic exec(input logic [63:0] a, input int len, input int sz,
                       input bit ext, input int rmode, input int cmode);
      logic [63:0] ea;
      int rem;
      bit seen;
      bit held;
      logic [63:0] h_addr;
      logic [10:0] h_len;
      logic [5:0]  h_tag;
      ea = a; rem = len; seen = 0; held = 0;
      h_addr = '0; h_len = '0; h_tag = '0;
      cmd_addr = a; cmd_len = len; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R8 busy", cmd_ready, 0);
      for (int cyc = 0; cyc < 4000 && !seen; cyc++) begin
         bit rdy;
         cpl_valid = 1'b0; cpl_last = 1'b0;
         rdy = (rmode == 0) || ((cyc % 3) != 1);
         req_ready = rdy;
         if (held)
            chk(req_valid && req_addr == h_addr && req_dw_len == h_len && req_tag == h_tag,
                "R7 hold", req_addr, h_addr);
         if (cmd_done) begin
            seen = 1;
            chk(rem == 0 && olist.size() == 0, "R8 done early", rem, 0);
         end else begin
            if (olist.size() > 0 && ((cyc % 2) == 0 || rem == 0)) begin
               int k;
               k = (cmode == 0) ? 0 : (cmode == 1) ? olist.size() - 1 : olist.size() / 2;
               cpl_tag = 6'(olist[k]);
               bmodel[olist[k]] = 1'b0;
               olist.delete(k);
               cpl_valid = 1'b1; cpl_last = 1'b1;
            end
            if (req_valid && rdy) begin
               int bnd;
               int sg;
               bnd = 4096 - int'(ea[11:0]);
               sg = rem;
               if (sg > sz) sg = sz;
               if (sg > bnd) sg = bnd;
               chk(rem > 0 && req_addr == ea, "R2 addr", req_addr, ea);
               chk(int'(req_dw_len) == sg / 4, "R3 len", req_dw_len, sg / 4);
               chk(!bmodel[req_tag] && (ext || req_tag < 6'd32), "R4 tag", req_tag, 0);
               bmodel[req_tag] = 1'b1;
               olist.push_back(int'(req_tag));
               ea = ea + 64'(sg);
               rem = rem - sg;
            end
         end
         held = req_valid && !rdy && !seen;
         h_addr = req_addr; h_len = req_dw_len; h_tag = req_tag;
         @(negedge clk);
      end
      cpl_valid = 1'b0;
      chk(seen, "R8 done seen", seen, 1);
      chk(cmd_done == 1'b0, "R8 done one cycle", cmd_done, 0);
   endtask

   task automatic get_req(output bit found, output logic [5:0] t);
      found = 0; t = '0;
      for (int w = 0; w < 50 && !found; w++) begin
         @(negedge clk);
         if (req_valid) begin found = 1; t = req_tag; end
      end
   endtask

   task automatic release_tag(input int t, input bit last);
      cpl_tag = 6'(t); cpl_last = last; cpl_valid = 1'b1;
      @(negedge clk);
      cpl_valid = 1'b0; cpl_last = 1'b0;
   endtask

   initial begin
      logic [63:0] addrs [5];
      int lens [4];
      bit fnd;
      logic [5:0] tg;
      int idx;
      addrs = '{64'h0, 64'hF00, 64'h1FFC, 64'h12340, 64'h1_0000_0FFC};
      lens  = '{4, 128, 900, 5000};

      dev_ctl = 16'hF02F;
      repeat (5) @(negedge clk);
      chk(req_valid == 0 && cmd_done == 0 && cmd_ready == 1, "R8 reset state", req_valid, 0);
      rst_n = 1'b1;
      // R1: first command after reset uses the 512-byte reset code
      exec(64'h1000, 2048, 512, 0, 0, 0);

      // R4 R5 R6: directed tag pool sequence with 128-byte requests
      dev_ctl = 16'h0000; ext_tag_en = 1'b0; req_ready = 1'b1;
      repeat (2) @(negedge clk);
      cmd_addr = 64'h0; cmd_len = 40 * 128; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 32; i++) begin
         get_req(fnd, tg);
         chk(fnd && tg == 6'(i), "R4 lowest tag", tg, i);
      end
      repeat (8) @(negedge clk);
      chk(req_valid == 1'b0, "R5 stall no tag", req_valid, 0);
      release_tag(7, 1'b0);
      repeat (3) @(negedge clk);
      chk(req_valid == 1'b0, "R6 non-last keeps tag", req_valid, 0);
      release_tag(7, 1'b1);
      get_req(fnd, tg);
      chk(fnd && tg == 6'd7, "R6 out-of-order release", tg, 7);
      ext_tag_en = 1'b1;
      for (int i = 0; i < 7; i++) begin
         get_req(fnd, tg);
         chk(fnd && tg == 6'(32 + i), "R4 extended tag", tg, 32 + i);
      end
      repeat (4) @(negedge clk);
      chk(req_valid == 1'b0 && cmd_done == 1'b0, "R8 no done with tags out", cmd_done, 0);
      for (int t = 38; t >= 0; t--) release_tag(t, 1'b1);
      fnd = 0;
      for (int w = 0; w < 20 && !fnd; w++) begin
         if (cmd_done) fnd = 1;
         else @(negedge clk);
      end
      chk(fnd, "R8 done after releases", fnd, 1);
      @(negedge clk);

      // R9: zero-length command
      exec(64'h40, 0, 512, 0, 0, 0);

      // R1 R2 R3: sweep over codes, start addresses and lengths
      idx = 0;
      for (int code = 0; code < 8; code++) begin
         for (int ai = 0; ai < 5; ai++) begin
            for (int li = 0; li < 4; li++) begin
               int sz;
               sz = (code > 5) ? 4096 : (128 << code);
               dev_ctl = {1'b0, 3'(code), 12'h2A5};
               ext_tag_en = idx[0];
               repeat (2) @(negedge clk);
               exec(addrs[ai], lens[li], sz, idx[0], idx % 2, idx % 3);
               idx++;
            end
         end
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule